// File: doc/BRIEF.md
# Burst-Mode AMI Line Framer

This block is the digital core of a ping-pong transceiver for one twisted pair. Both directions share the pair by taking turns. On the transmit side it accepts 36 payload bits, which carry the two bearer channels and the signalling channel of two consecutive frames. It sends a start mark, then the payload after scrambling, as a stream of ternary symbols with alternate mark inversion. On the receive side it takes ternary symbols that an analog front end has already detected. It locks onto the start mark, descrambles the 36 symbols that follow, and delivers them as one parallel word. It also records any breach of the alternating-mark rule.

All symbol timing comes in as a clock enable, `sym_en`, which marks one symbol period. The block does nothing between enables. While a burst is being sent, the receive input is ignored. After a burst has been received, the receiver waits out a fixed guard interval and then reports that the line may be turned around. The framer never starts a burst on its own. A burst begins only when `tx_start` is accepted, so the burst repetition rate (4 kHz in normal use) is set by the caller.

Symbol code on `tx_sym` and `rx_sym`: 2'b00 is no pulse, 2'b01 is a positive mark, 2'b11 is a negative mark, and 2'b10 is reserved.

Top module: `ami_burst_framer`

## Requirements
- R1: The first symbol of each transmit burst is a mark. It stands for an unscrambled 1, and its polarity is opposite to the last mark sent before it, including marks sent in earlier bursts. After reset the first mark sent is positive.
- R2: The 36 payload symbols follow the start mark in the order tx_payload[35] down to tx_payload[0]. Frame one fills bits 35..18 (first bearer channel 35..28, second bearer channel 27..20, signalling 19..18), and frame two fills bits 17..0 in the same layout.
- R3: Each payload bit d is sent as s = d XOR s(n-5) XOR s(n-9), where s(n-k) is the k-th earlier scrambled payload bit. The history is all zeros after reset, carries on from one burst to the next, and never includes the start mark.
- R4: A 0 is sent as 2'b00. A 1 is sent as a mark, and its polarity is opposite to the previous mark. The code 2'b10 is never driven.
- R5: A burst accepted from `tx_start` takes exactly 37 symbol ticks, with one `tx_sym_vld` pulse per symbol. `tx_busy` is high from the cycle after acceptance until the tick after the last symbol, and `tx_sym` then returns to 2'b00. A `tx_start` that arrives while `tx_busy` is high is ignored.
- R6: While `tx_busy` is high, `rx_sym` is ignored. It starts no burst, feeds no descrambler bit and sets no violation.
- R7: When the receiver is idle, any mark is taken as the start mark. The next 36 symbols are descrambled with the inverse of R3 (with a zero history after reset). The first of them lands in rx_payload[35]. `rx_payload` is updated and `rx_valid` pulses for one cycle in the cycle after the tick of the 36th symbol.
- R8: Two received marks in a row with the same polarity set `rx_bpv`. Start marks count towards this rule, and any 2'b00 symbols between the two marks do not matter. `rx_bpv` stays set until `bpv_clr`, and a new violation in the same cycle as `bpv_clr` wins.
- R9: After the 36th payload symbol, the receiver spends exactly 6 symbol ticks in a guard state. `turn_ok` pulses for one cycle in the cycle after the sixth tick.
- R10: A received 2'b10 is decoded as a 0 (no pulse).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_en | input | 1 | One-cycle symbol tick |
| tx_start | input | 1 | Request to send one burst |
| tx_payload | input | 36 | Payload of two frames, sampled at acceptance |
| tx_busy | output | 1 | Transmit burst in progress |
| tx_sym | output | 2 | Ternary transmit symbol |
| tx_sym_vld | output | 1 | Pulses when a new transmit symbol is presented |
| rx_sym | input | 2 | Detected ternary receive symbol |
| bpv_clr | input | 1 | Clears the violation flag |
| rx_payload | output | 36 | Last received payload |
| rx_valid | output | 1 | One-cycle strobe for a new rx_payload |
| rx_bpv | output | 1 | Sticky alternating-mark violation flag |
| turn_ok | output | 1 | One-cycle pulse at the end of the receive guard |

## Verification
The assertions assume that `rx_sym` is sampled only on `sym_en` ticks and that `tx_start` and `bpv_clr` are single-cycle, synchronous pulses. They also assume that the receive state may move only on a tick that arrives while no transmit burst is in progress. The stimulus raises `sym_en` for one cycle in every four. It changes `rx_sym` only in the cycle just before a tick, and it drives every request for exactly one cycle. Receive streams are built by an independent model of the scrambler and the mark alternation. A few deliberate defects are added to that stream: a repeated polarity and a reserved code. Marks are also driven on purpose while a transmit burst is running.

// File: rtl/ami_framer_pkg.sv
package ami_framer_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_POS  = 2'b01,
    SYM_RSV  = 2'b10,
    SYM_NEG  = 2'b11
  } ami_sym_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'b00,
    RX_DATA  = 2'b01,
    RX_GUARD = 2'b10
  } rx_state_e;
endpackage

// File: rtl/ami_scrambler.sv
module ami_scrambler #(
  parameter int LEN   = 9,
  parameter int TAP   = 5,
  parameter bit DESCR = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic din,
  output logic dout
);
  logic [LEN-1:0] hist;
  logic           fb;

  // hist[0] holds the newest line bit, hist[k-1] the bit k steps ago
  assign dout = din ^ hist[TAP-1] ^ hist[LEN-1];

  generate
    if (DESCR) begin : g_descr
      assign fb = din;
    end else begin : g_scr
      assign fb = dout;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else if (step) hist <= {hist[LEN-2:0], fb};
  end
endmodule

// File: rtl/ami_mark_mapper.sv
module ami_mark_mapper
  import ami_framer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       bit_in,
  output logic [1:0] code
);
  logic prev_neg;

  always_comb begin
    if (!bit_in) code = SYM_ZERO;
    else if (prev_neg) code = SYM_POS;
    else code = SYM_NEG;
  end

  always_ff @(posedge clk) begin
    if (rst) prev_neg <= 1'b1;
    else if (step && bit_in) prev_neg <= ~prev_neg;
  end
endmodule

// File: rtl/ami_tx_burst.sv
module ami_tx_burst
  import ami_framer_pkg::*;
#(
  parameter int PAY_BITS = 36,
  parameter int SCR_LEN  = 9,
  parameter int SCR_TAP  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sym_en,
  input  logic                start,
  input  logic [PAY_BITS-1:0] payload,
  output logic                busy,
  output logic [1:0]          sym,
  output logic                sym_vld
);
  localparam int IDX_W = $clog2(PAY_BITS + 2);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAY_BITS);

  logic [PAY_BITS-1:0] pay_q;
  logic [IDX_W-1:0]    idx;
  logic                first_q;
  logic                is_start, emit, scr_out, line_bit;
  logic [1:0]          code;

  assign is_start = (idx == '0);
  assign emit     = busy && sym_en && (idx <= LAST_IDX);
  assign line_bit = is_start ? 1'b1 : scr_out;

  ami_scrambler #(.LEN(SCR_LEN), .TAP(SCR_TAP), .DESCR(1'b0)) u_scr (
    .clk(clk), .rst(rst), .step(emit && !is_start),
    .din(pay_q[PAY_BITS-1]), .dout(scr_out)
  );

  ami_mark_mapper u_map (
    .clk(clk), .rst(rst), .step(emit), .bit_in(line_bit), .code(code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pay_q   <= '0;
      idx     <= '0;
      busy    <= 1'b0;
      sym     <= SYM_ZERO;
      sym_vld <= 1'b0;
      first_q <= 1'b0;
    end else begin
      sym_vld <= 1'b0;
      if (!busy) begin
        if (start) begin
          pay_q <= payload;
          idx   <= '0;
          busy  <= 1'b1;
        end
      end else if (sym_en) begin
        if (idx <= LAST_IDX) begin
          sym     <= code;
          sym_vld <= 1'b1;
          first_q <= is_start;
          idx     <= idx + 1'b1;
          if (!is_start) pay_q <= pay_q << 1;
        end else begin
          busy <= 1'b0;
          sym  <= SYM_ZERO;
        end
      end
    end
  end

  // R1: the symbol sent first in a burst is always a pulse
  assert_start_mark_R1: assert property (@(posedge clk) disable iff (rst)
    (sym_vld && first_q) |-> (sym != SYM_ZERO));

  // R4: reserved code never reaches the line
  assert_sym_legal_R4: assert property (@(posedge clk) disable iff (rst)
    sym != SYM_RSV);
endmodule

// File: rtl/ami_rx_burst.sv
module ami_rx_burst
  import ami_framer_pkg::*;
#(
  parameter int PAY_BITS   = 36,
  parameter int GUARD_SYMS = 6,
  parameter int SCR_LEN    = 9,
  parameter int SCR_TAP    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sym_en,
  input  logic                hold,
  input  logic [1:0]          sym,
  input  logic                bpv_clr,
  output logic [PAY_BITS-1:0] payload,
  output logic                valid,
  output logic                bpv,
  output logic                turn_ok
);
  localparam int CNT_MAX = (PAY_BITS > GUARD_SYMS) ? PAY_BITS : GUARD_SYMS;
  localparam int CNT_W   = $clog2(CNT_MAX + 2);
  localparam logic [CNT_W-1:0] LAST_PAY = CNT_W'(PAY_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_GRD = CNT_W'(GUARD_SYMS - 1);

  rx_state_e             st;
  logic [CNT_W-1:0]      cnt;
  logic [PAY_BITS-2:0]   shreg;
  logic                  tick, is_mark, is_neg, watch, viol, dbit;
  logic                  seen_mark, last_neg;

  assign tick    = sym_en && !hold;
  assign is_mark = (sym == SYM_POS) || (sym == SYM_NEG);
  assign is_neg  = (sym == SYM_NEG);
  assign watch   = tick && is_mark && (st != RX_GUARD);
  assign viol    = watch && seen_mark && (is_neg == last_neg);

  ami_scrambler #(.LEN(SCR_LEN), .TAP(SCR_TAP), .DESCR(1'b1)) u_descr (
    .clk(clk), .rst(rst), .step(tick && (st == RX_DATA)),
    .din(is_mark), .dout(dbit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_mark <= 1'b0;
      last_neg  <= 1'b0;
      bpv       <= 1'b0;
    end else begin
      if (watch) begin
        seen_mark <= 1'b1;
        last_neg  <= is_neg;
      end
      if (bpv_clr) bpv <= 1'b0;
      if (viol) bpv <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= RX_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      payload <= '0;
      valid   <= 1'b0;
      turn_ok <= 1'b0;
    end else begin
      valid   <= 1'b0;
      turn_ok <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: begin
            if (is_mark) begin
              st  <= RX_DATA;
              cnt <= '0;
            end
          end
          RX_DATA: begin
            shreg <= {shreg[PAY_BITS-3:0], dbit};
            if (cnt == LAST_PAY) begin
              payload <= {shreg, dbit};
              valid   <= 1'b1;
              st      <= RX_GUARD;
              cnt     <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_GUARD: begin
            if (cnt == LAST_GRD) begin
              turn_ok <= 1'b1;
              st      <= RX_IDLE;
              cnt     <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R6: no receive progress while the local transmitter holds the line
  assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(st));

  // R7: the payload strobe lasts a single cycle
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R8: the violation flag only drops on request
  assert_bpv_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (bpv && !bpv_clr) |=> bpv);

  // R9: turnaround is reported only on leaving the guard state
  assert_guard_turn_R9: assert property (@(posedge clk) disable iff (rst)
    turn_ok |-> (st == RX_IDLE && $past(st) == RX_GUARD));
endmodule

// File: rtl/ami_burst_framer.sv
module ami_burst_framer
  import ami_framer_pkg::*;
#(
  parameter int PAY_BITS   = 36,
  parameter int GUARD_SYMS = 6,
  parameter int SCR_LEN    = 9,
  parameter int SCR_TAP    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sym_en,
  input  logic                tx_start,
  input  logic [PAY_BITS-1:0] tx_payload,
  output logic                tx_busy,
  output logic [1:0]          tx_sym,
  output logic                tx_sym_vld,
  input  logic [1:0]          rx_sym,
  input  logic                bpv_clr,
  output logic [PAY_BITS-1:0] rx_payload,
  output logic                rx_valid,
  output logic                rx_bpv,
  output logic                turn_ok
);
  ami_tx_burst #(
    .PAY_BITS(PAY_BITS), .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)
  ) u_tx (
    .clk(clk), .rst(rst), .sym_en(sym_en), .start(tx_start),
    .payload(tx_payload), .busy(tx_busy), .sym(tx_sym), .sym_vld(tx_sym_vld)
  );

  ami_rx_burst #(
    .PAY_BITS(PAY_BITS), .GUARD_SYMS(GUARD_SYMS),
    .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)
  ) u_rx (
    .clk(clk), .rst(rst), .sym_en(sym_en), .hold(tx_busy), .sym(rx_sym),
    .bpv_clr(bpv_clr), .payload(rx_payload), .valid(rx_valid),
    .bpv(rx_bpv), .turn_ok(turn_ok)
  );
endmodule

// File: tb/ami_burst_framer_tb.sv
`timescale 1ns/1ps
module ami_burst_framer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sym_en = 1'b0;
  logic        tx_start = 1'b0;
  logic [35:0] tx_payload = '0;
  logic        tx_busy, tx_sym_vld, rx_valid, rx_bpv, turn_ok;
  logic [1:0]  tx_sym;
  logic [1:0]  rx_sym = 2'b00;
  logic        bpv_clr = 1'b0;
  logic [35:0] rx_payload;

  int total = 0;
  int bad = 0;
  int n_valid = 0;
  int gcnt = 0;
  bit gcount_on = 0;
  bit finished = 0;

  logic [2:0]  txq[$];
  logic [35:0] rxq[$];
  string       rxtag[$];

  // bench models: transmit side and the far-end encoder for receive streams
  logic [8:0]  m_tscr = '0;
  logic        m_tneg = 1'b1;
  logic [8:0]  m_escr = '0;
  logic        m_eneg = 1'b1;
  logic [1:0]  stream[37];

  always #2.5 clk = ~clk;

  ami_burst_framer dut_i (
    .clk(clk), .rst(rst), .sym_en(sym_en), .tx_start(tx_start),
    .tx_payload(tx_payload), .tx_busy(tx_busy), .tx_sym(tx_sym),
    .tx_sym_vld(tx_sym_vld), .rx_sym(rx_sym), .bpv_clr(bpv_clr),
    .rx_payload(rx_payload), .rx_valid(rx_valid), .rx_bpv(rx_bpv),
    .turn_ok(turn_ok)
  );

  int tick_div = 0;
  always @(posedge clk) begin
    tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
    sym_en   <= (tick_div == 3);
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] got,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [1:0] mark_code(input logic neg);
    return neg ? 2'b11 : 2'b01;
  endfunction

  // expected transmit symbols per R1..R4
  task automatic push_tx_model(input logic [35:0] p);
    logic s;
    txq.push_back({1'b1, mark_code(!m_tneg)});
    m_tneg = !m_tneg;
    for (int i = 35; i >= 0; i--) begin
      s = p[i] ^ m_tscr[4] ^ m_tscr[8];
      m_tscr = {m_tscr[7:0], s};
      if (s) begin
        txq.push_back({1'b0, mark_code(!m_tneg)});
        m_tneg = !m_tneg;
      end else begin
        txq.push_back(3'b000);
      end
    end
  endtask

  task automatic build_stream(input logic [35:0] p);
    logic s;
    stream[0] = mark_code(!m_eneg);
    m_eneg = !m_eneg;
    for (int i = 35; i >= 0; i--) begin
      s = p[i] ^ m_escr[4] ^ m_escr[8];
      m_escr = {m_escr[7:0], s};
      if (s) begin
        stream[36 - i] = mark_code(!m_eneg);
        m_eneg = !m_eneg;
      end else begin
        stream[36 - i] = 2'b00;
      end
    end
  endtask

  task automatic rx_put(input logic [1:0] s);
    do @(negedge clk); while (!sym_en);
    rx_sym = s;
    @(posedge clk);
  endtask

  task automatic send_stream();
    for (int i = 0; i < 37; i++) rx_put(stream[i]);
    for (int i = 0; i < 9; i++) rx_put(2'b00);
  endtask

  task automatic start_tx(input logic [35:0] p);
    @(negedge clk);
    while (tx_busy) @(negedge clk);
    tx_start = 1'b1;
    tx_payload = p;
    push_tx_model(p);
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  task automatic wait_tx_done();
    @(negedge clk);
    while (tx_busy) @(negedge clk);
  endtask

  // monitor: pops the scoreboards as results appear
  always @(negedge clk) begin
    logic [2:0]  e;
    logic [35:0] ep;
    string       t;
    if (!rst) begin
      if (tx_sym_vld) begin
        if (txq.size() == 0) begin
          chk(1'b0, "R5 unexpected tx symbol", {62'd0, tx_sym}, 64'd0);
        end else begin
          e = txq.pop_front();
          if (e[2]) chk(tx_sym == e[1:0], "R1 start mark", {62'd0, tx_sym}, {62'd0, e[1:0]});
          else chk(tx_sym == e[1:0], "R2 R3 R4 payload symbol", {62'd0, tx_sym}, {62'd0, e[1:0]});
        end
      end
      if (gcount_on && turn_ok) begin
        chk(gcnt == 6, "R9 guard ticks", 64'(gcnt), 64'd6);
        gcount_on = 0;
      end
      if (rx_valid) begin
        n_valid++;
        if (rxq.size() == 0) begin
          chk(1'b0, "R6 unexpected rx_valid", {28'd0, rx_payload}, 64'd0);
        end else begin
          ep = rxq.pop_front();
          t  = rxtag.pop_front();
          chk(rx_payload == ep, t, {28'd0, rx_payload}, {28'd0, ep});
        end
        gcnt = 0;
        gcount_on = 1;
      end else if (gcount_on && sym_en) begin
        gcnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [35:0] p;
    int v0;
    int a;
    repeat (5) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_busy == 0 && tx_sym == 2'b00 && tx_sym_vld == 0, "R5 reset tx idle",
        {61'd0, tx_busy, tx_sym}, 64'd0);
    chk(rx_valid == 0 && rx_bpv == 0 && turn_ok == 0, "R8 reset rx idle",
        {61'd0, rx_valid, rx_bpv, turn_ok}, 64'd0);

    // transmit: several payloads, second request while busy
    start_tx(36'h9A5C30F1E);
    repeat (20) @(negedge clk);
    tx_start = 1'b1; tx_payload = 36'h123456789;
    @(negedge clk);
    tx_start = 1'b0;
    wait_tx_done();
    chk(txq.size() == 0, "R5 burst length", 64'(txq.size()), 64'd0);
    chk(tx_sym == 2'b00, "R5 line quiet after burst", {62'd0, tx_sym}, 64'd0);
    start_tx(36'hFFFFFFFFF);
    wait_tx_done();
    start_tx(36'h000000000);
    wait_tx_done();
    chk(txq.size() == 0, "R3 all tx symbols seen", 64'(txq.size()), 64'd0);

    // receive: clean bursts
    p = 36'hC3A5F0017;
    build_stream(p);
    rxq.push_back(p); rxtag.push_back("R7 rx payload clean");
    send_stream();
    p = 36'h0FEDCBA98;
    build_stream(p);
    rxq.push_back(p); rxtag.push_back("R7 rx payload second");
    send_stream();

    // reserved code in place of a no-pulse symbol
    p = 36'h5A5A5A5A5;
    build_stream(p);
    for (int i = 1; i < 37; i++) begin
      if (stream[i] == 2'b00) begin
        stream[i] = 2'b10;
        break;
      end
    end
    rxq.push_back(p); rxtag.push_back("R10 reserved code as zero");
    send_stream();
    chk(rx_bpv == 0, "R10 no violation from reserved", {63'd0, rx_bpv}, 64'd0);

    // repeated polarity
    p = 36'h3C3C3C3C3;
    build_stream(p);
    a = 0;
    for (int i = 1; i < 37; i++) begin
      if (stream[i] != 2'b00 && a == 0) a = i;
    end
    stream[a] = stream[0];
    rxq.push_back(p); rxtag.push_back("R8 payload with violation");
    send_stream();
    chk(rx_bpv == 1, "R8 violation flagged", {63'd0, rx_bpv}, 64'd1);
    p = 36'h00FF00FF0;
    build_stream(p);
    rxq.push_back(p); rxtag.push_back("R8 payload clean after");
    send_stream();
    chk(rx_bpv == 1, "R8 flag sticky", {63'd0, rx_bpv}, 64'd1);
    @(negedge clk);
    bpv_clr = 1'b1;
    @(negedge clk);
    bpv_clr = 1'b0;
    chk(rx_bpv == 0, "R8 flag cleared", {63'd0, rx_bpv}, 64'd0);
    p = 36'h876543210;
    build_stream(p);
    rxq.push_back(p); rxtag.push_back("R8 payload after clear");
    send_stream();
    chk(rx_bpv == 0, "R8 stays clear on legal burst", {63'd0, rx_bpv}, 64'd0);

    // receive input during own transmit burst
    v0 = n_valid;
    start_tx(36'hABCDEF012);
    @(negedge clk);
    for (int i = 0; i < 37; i++) rx_put(i[0] ? 2'b01 : 2'b01);
    rx_sym = 2'b00;
    wait_tx_done();
    for (int i = 0; i < 10; i++) rx_put(2'b00);
    chk(n_valid == v0, "R6 no burst while transmitting", 64'(n_valid), 64'(v0));
    chk(rx_bpv == 0, "R6 no violation while transmitting", {63'd0, rx_bpv}, 64'd0);
    p = 36'h13579BDF0;
    build_stream(p);
    rxq.push_back(p); rxtag.push_back("R6 rx state untouched");
    send_stream();
    chk(rx_bpv == 0, "R6 polarity memory untouched", {63'd0, rx_bpv}, 64'd0);

    repeat (20) @(negedge clk);
    chk(rxq.size() == 0, "R7 all rx bursts delivered", 64'(rxq.size()), 64'd0);
    chk(txq.size() == 0, "R2 all tx symbols seen", 64'(txq.size()), 64'd0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule